// File: doc/BRIEF.md
# Linked-List Block Buffer Manager

This block runs a single shared data memory that is cut into blocks of four dwords each. Channels do not own a contiguous region. Instead, each channel owns a ring of blocks that may sit anywhere in the memory. Software builds the ring by writing two tables. One table holds, for each block, the index of the block that follows it. The other table holds, for each channel, an entry block, which may be any member of the ring. Arming a channel does three things: it sets the channel's capacity as a number of blocks, points both of its cursors at the entry block, and empties it.

Each channel keeps a write cursor and a read cursor. A cursor is a block index plus a dword offset within that block. Data moves through one write port and one read port, and each port carries a channel index. Once a cursor has used all four dwords of a block, it follows the link table to the next block and starts again at offset 0. Each channel also keeps a fill count in dwords. The block compares this count with two thresholds: a high mark, used on the receive side, and a low mark, used on the transmit side. A write to a full channel and a read from an empty channel are refused, and each refusal raises a one-cycle error pulse. Choosing which channel to serve is left to the logic around the block.

Top module: `lfifo_mgr`

## Requirements
- R1: After reset, every fill count is 0. This makes `tx_req` 1 for every channel, makes `rx_flag` 0 whenever `hi_wm` is nonzero, and holds `rd_valid`, `overflow` and `underflow` at 0. Capacity is also 0 until a channel is armed, so every write to an unarmed channel overflows.
- R2: Data read from a channel comes back in the order it was written. An accepted read in cycle N drives `rd_valid`=1 and the dword on `rd_data` in cycle N+1.
- R3: A write to a channel whose fill count equals 4 × its ring length is dropped, and `overflow` is 1 in the next cycle. The fill count never goes above that capacity.
- R4: A read from a channel whose fill count is 0 returns no data. In the next cycle `underflow` is 1 and `rd_valid` is 0.
- R5: A cursor follows the link table after every 4th dword. Data therefore stays correct while a ring wraps around many times, whatever block the entry pointer names.
- R6: `cfg_op`=3 arms the channel given by `cfg_addr`, using `cfg_data` as the ring length in blocks. Arming empties the channel, discards any data it held, and moves both cursors to its entry block. A data access to that channel in the same cycle is discarded with no flag.
- R7: `rx_flag[c]` is 1 exactly when channel c's fill count is greater than or equal to `hi_wm`.
- R8: `tx_req[c]` is 1 exactly when channel c's fill count is less than or equal to `lo_wm`.
- R9: A read and a write to the same channel in the same cycle both take effect, and each is judged on the fill count from before that cycle. A ring that is not empty therefore keeps its fill count. An empty ring reports underflow and still accepts the write.
- R10: Channels are independent of one another. Traffic on one channel never changes the data or fill count of another, even when their blocks are interleaved in memory.
- R11: `cfg_op`=1 writes `cfg_data` as the entry block of channel `cfg_addr`. `cfg_op`=2 writes `cfg_data` as the link of block `cfg_addr`. `cfg_op`=0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_op | input | 2 | Host operation: 0 none, 1 entry pointer, 2 link, 3 arm channel |
| cfg_addr | input | AW | Channel or block index for the operation |
| cfg_data | input | LW | Block index, or ring length in blocks when arming |
| hi_wm | input | NW | Receive threshold in dwords |
| lo_wm | input | NW | Transmit threshold in dwords |
| wr_en | input | 1 | Write request |
| wr_ch | input | CW | Channel to write |
| wr_data | input | DW | Dword to store |
| rd_en | input | 1 | Read request |
| rd_ch | input | CW | Channel to read |
| rd_data | output | DW | Dword read, valid with rd_valid |
| rd_valid | output | 1 | A read was accepted in the previous cycle |
| overflow | output | 1 | A write was refused in the previous cycle |
| underflow | output | 1 | A read was refused in the previous cycle |
| rx_flag | output | NUM_CH | Per-channel fill count at or above hi_wm |
| tx_req | output | NUM_CH | Per-channel fill count at or below lo_wm |

## Verification
The hardest case to reach from the ports is a cursor moving from one scattered block to the next while another channel's blocks sit between them in memory. Only then does a broken link walk overwrite a neighbour's data. The stimulus builds two rings whose blocks alternate through the memory, with entry pointers in the middle of each ring. It fills both rings to the brim, reading nothing until both are full, and then drains them. It then drives short write/read bursts whose lengths do not divide the ring size, so that the wrap point falls at a different block offset on each pass.

// File: rtl/lfifo_mgr.sv
module lfifo_mgr #(
  parameter int NUM_BLOCKS = 256,
  parameter int NUM_CH     = 16,
  parameter int DW         = 32,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int CW = $clog2(NUM_CH),
  localparam int AW = (BW > CW) ? BW : CW,
  localparam int LW = BW + 1,
  localparam int NW = BW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_op,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [LW-1:0]     cfg_data,
  input  logic [NW-1:0]     hi_wm,
  input  logic [NW-1:0]     lo_wm,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_ch,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [CW-1:0]     rd_ch,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              overflow,
  output logic              underflow,
  output logic [NUM_CH-1:0] rx_flag,
  output logic [NUM_CH-1:0] tx_req
);

  logic [BW-1:0] start_ptr [NUM_CH];
  logic [BW-1:0] next_ptr  [NUM_BLOCKS];
  logic [BW-1:0] wblk      [NUM_CH];
  logic [BW-1:0] rblk      [NUM_CH];
  logic [1:0]    woff      [NUM_CH];
  logic [1:0]    roff      [NUM_CH];
  logic [LW-1:0] chain_len [NUM_CH];
  logic [NW-1:0] cnt       [NUM_CH];
  logic [DW-1:0] mem       [NUM_BLOCKS*4];

  wire          en_op   = (cfg_op == 2'd3);
  wire [CW-1:0] en_ch   = cfg_addr[CW-1:0];
  wire          wr_kill = en_op && (en_ch == wr_ch);
  wire          rd_kill = en_op && (en_ch == rd_ch);

  wire [NW-1:0] wr_fill  = cnt[wr_ch];
  wire [NW-1:0] wr_cap   = {chain_len[wr_ch], 2'b00};
  wire          wr_full  = (wr_fill == wr_cap);
  wire          rd_empty = (cnt[rd_ch] == '0);

  wire wr_go = wr_en && !wr_kill && !wr_full;
  wire rd_go = rd_en && !rd_kill && !rd_empty;

  wire [BW+1:0] waddr = {wblk[wr_ch], woff[wr_ch]};
  wire [BW+1:0] raddr = {rblk[rd_ch], roff[rd_ch]};

  always_ff @(posedge clk) begin
    if (wr_go) mem[waddr] <= wr_data;
    if (rd_go) rd_data <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      rd_valid  <= rd_go;
      overflow  <= wr_en && !wr_kill && wr_full;
      underflow <= rd_en && !rd_kill && rd_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) start_ptr[i] <= '0;
      for (int i = 0; i < NUM_BLOCKS; i++) next_ptr[i] <= '0;
    end else if (cfg_op == 2'd1) begin
      start_ptr[cfg_addr[CW-1:0]] <= cfg_data[BW-1:0];
    end else if (cfg_op == 2'd2) begin
      next_ptr[cfg_addr[BW-1:0]] <= cfg_data[BW-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wire w_here = wr_go && (wr_ch == CW'(c));
    wire r_here = rd_go && (rd_ch == CW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wblk[c]      <= '0;
        rblk[c]      <= '0;
        woff[c]      <= '0;
        roff[c]      <= '0;
        cnt[c]       <= '0;
        chain_len[c] <= '0;
      end else if (en_op && en_ch == CW'(c)) begin
        wblk[c]      <= start_ptr[c];
        rblk[c]      <= start_ptr[c];
        woff[c]      <= '0;
        roff[c]      <= '0;
        cnt[c]       <= '0;
        chain_len[c] <= cfg_data;
      end else begin
        if (w_here) begin
          woff[c] <= woff[c] + 2'd1;
          if (woff[c] == 2'd3) wblk[c] <= next_ptr[wblk[c]];
        end
        if (r_here) begin
          roff[c] <= roff[c] + 2'd1;
          if (roff[c] == 2'd3) rblk[c] <= next_ptr[rblk[c]];
        end
        cnt[c] <= cnt[c] + NW'(w_here) - NW'(r_here);
      end
    end

    assign rx_flag[c] = (cnt[c] >= hi_wm);
    assign tx_req[c]  = (cnt[c] <= lo_wm);
  end

endmodule

module lfifo_mgr_chk #(
  parameter int NW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          wr_kill,
  input logic          rd_kill,
  input logic          wr_full,
  input logic          rd_empty,
  input logic [NW-1:0] wr_fill,
  input logic [NW-1:0] wr_cap,
  input logic          rd_valid,
  input logic          overflow,
  input logic          underflow
);

  a_r3_refused_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_kill && wr_full) |=> overflow);

  a_r3_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fill <= wr_cap);

  a_r4_refused_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_kill && rd_empty) |=> (underflow && !rd_valid));

  a_r2_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  a_r4_valid_excludes_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && underflow));

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rd_valid && !overflow && !underflow));

endmodule

bind lfifo_mgr lfifo_mgr_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .wr_kill(wr_kill), .rd_kill(rd_kill), .wr_full(wr_full), .rd_empty(rd_empty),
  .wr_fill(wr_fill), .wr_cap(wr_cap), .rd_valid(rd_valid),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/lfifo_mgr_test.sv
module lfifo_mgr_test;
  localparam int NB = 64, NC = 8, DW = 32;
  localparam int CW = 3, AW = 6, LW = 7, NW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_op = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [LW-1:0] cfg_data = '0;
  logic [NW-1:0] hi_wm = NW'(6), lo_wm = NW'(2);
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [CW-1:0] wr_ch = '0, rd_ch = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, overflow, underflow;
  logic [NC-1:0] rx_flag, tx_req;

  lfifo_mgr #(.NUM_BLOCKS(NB), .NUM_CH(NC), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_op(cfg_op), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .hi_wm(hi_wm), .lo_wm(lo_wm), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data), .rd_valid(rd_valid),
    .overflow(overflow), .underflow(underflow), .rx_flag(rx_flag), .tx_req(tx_req));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct packed {
    int unsigned at;
    logic rv, ov, un;
    logic [31:0] d;
  } exp_t;
  exp_t eq[$];
  string tq[$];

  logic [31:0] md [NC][256];
  int mh[NC], mc[NC], mcap[NC];

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (eq.size() > 0 && eq[0].at == cyc) begin
      exp_t e;
      string t;
      e = eq.pop_front();
      t = tq.pop_front();
      checks++;
      if (rd_valid !== e.rv || overflow !== e.ov || underflow !== e.un ||
          (e.rv && rd_data !== e.d)) begin
        fails++;
        $display("FAIL %s: rv=%0b ov=%0b un=%0b data=%h expected rv=%0b ov=%0b un=%0b data=%h",
                 t, rd_valid, overflow, underflow, rd_data, e.rv, e.ov, e.un, e.d);
      end
    end else if (rst_n && (rd_valid || overflow || underflow)) begin
      checks++;
      fails++;
      $display("FAIL R2: unexpected rv=%0b ov=%0b un=%0b expected all 0", rd_valid, overflow, underflow);
    end
  end

  task automatic drive(input bit dw, input int wc, input logic [31:0] wd,
                       input bit dr, input int rc, input string tag);
    exp_t e;
    bit rok, wok;
    @(negedge clk);
    wr_en = dw; wr_ch = CW'(wc); wr_data = wd;
    rd_en = dr; rd_ch = CW'(rc);
    e = '{at: cyc + 1, rv: 1'b0, ov: 1'b0, un: 1'b0, d: '0};
    rok = dr && mc[rc] > 0;
    wok = dw && mc[wc] < mcap[wc];
    if (dr && !rok) e.un = 1'b1;
    if (dw && !wok) e.ov = 1'b1;
    if (rok) begin
      e.rv = 1'b1; e.d = md[rc][mh[rc]];
      mh[rc] = (mh[rc] + 1) % 256; mc[rc]--;
    end
    if (wok) begin
      md[wc][(mh[wc] + mc[wc]) % 256] = wd; mc[wc]++;
    end
    if (dw || dr) begin eq.push_back(e); tq.push_back(tag); end
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input int c, input logic [31:0] d, input string tag);
    drive(1, c, d, 0, 0, tag);
  endtask
  task automatic rd(input int c, input string tag);
    drive(0, 0, '0, 1, c, tag);
  endtask

  task automatic cfg(input int op, input int a, input int d);
    @(negedge clk);
    cfg_op = 2'(op); cfg_addr = AW'(a); cfg_data = LW'(d);
    if (op == 3) begin mh[a] = 0; mc[a] = 0; mcap[a] = d * 4; end
    @(posedge clk); #1;
    cfg_op = '0;
  endtask

  task automatic ring(input int c, input int blks[], input int entry);
    for (int i = 0; i < blks.size(); i++) cfg(2, blks[i], blks[(i + 1) % blks.size()]);
    cfg(1, c, entry);
    cfg(3, c, blks.size());
  endtask

  task automatic chk_flags(input string tag);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      checks++;
      if (rx_flag[c] !== (mc[c] >= int'(hi_wm)) || tx_req[c] !== (mc[c] <= int'(lo_wm))) begin
        fails++;
        $display("FAIL %s: ch%0d rx=%0b tx=%0b expected rx=%0b tx=%0b (fill %0d)",
                 tag, c, rx_flag[c], tx_req[c], mc[c] >= int'(hi_wm), mc[c] <= int'(lo_wm), mc[c]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    for (int c = 0; c < NC; c++) begin mh[c] = 0; mc[c] = 0; mcap[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet outputs and threshold flags after reset
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || overflow !== 1'b0 || underflow !== 1'b0) begin
      fails++;
      $display("FAIL R1: rv=%0b ov=%0b un=%0b expected 0 0 0", rd_valid, overflow, underflow);
    end
    chk_flags("R1");
    wr(3, 32'h1, "R1 unarmed write overflows");

    // R11 / R5: two interleaved scattered rings, entry points mid-ring
    ring(0, '{5, 40, 12, 33, 20}, 12);
    ring(1, '{6, 41, 13, 34}, 34);
    ring(2, '{0, 1, 2, 3}, 0);

    // R10 / R3: fill both rings completely, then one extra write each
    for (int i = 0; i < 20; i++) begin
      wr(0, 32'hA000 + i, "R10");
      if (i < 16) wr(1, 32'hB000 + i, "R10");
    end
    wr(0, 32'hDEAD0, "R3 full ring 0");
    wr(1, 32'hDEAD1, "R3 full ring 1");
    chk_flags("R7 R8 full rings");

    // R2 / R5: drain in order across block links
    for (int i = 0; i < 20; i++) rd(0, "R5 ring 0 drain");
    for (int i = 0; i < 16; i++) rd(1, "R2 ring 1 drain");
    rd(0, "R4 empty read");
    rd(1, "R4 empty read");

    // R5: wrap ring 1 many times at shifting offsets
    for (int r = 0; r < 9; r++) begin
      for (int i = 0; i < 7; i++) wr(1, 32'hC000 + r * 16 + i, "R5 wrap write");
      for (int i = 0; i < 7; i++) rd(1, "R5 wrap read");
    end

    // R9: simultaneous read and write on one channel
    drive(1, 2, 32'hE000, 1, 2, "R9 both on empty");
    for (int i = 1; i < 4; i++) wr(2, 32'hE000 + i, "R9 preload");
    for (int i = 4; i < 12; i++) drive(1, 2, 32'hE000 + i, 1, 2, "R9 both");
    chk_flags("R9 fill kept");
    for (int i = 0; i < 3; i++) rd(2, "R9 drain");

    // R7 / R8: walk thresholds one dword at a time
    for (int i = 0; i < 8; i++) begin
      wr(2, 32'hF000 + i, "R7 step");
      chk_flags("R7 R8 threshold");
    end
    for (int i = 0; i < 8; i++) begin
      rd(2, "R8 step");
      chk_flags("R7 R8 threshold");
    end

    // R6: rearm discards data; same-cycle access is dropped silently
    for (int i = 0; i < 5; i++) wr(2, 32'h5000 + i, "R6 preload");
    @(negedge clk);
    cfg_op = 2'd3; cfg_addr = AW'(2); cfg_data = LW'(4);
    wr_en = 1'b1; wr_ch = CW'(2); wr_data = 32'hBAD;
    mh[2] = 0; mc[2] = 0; mcap[2] = 16;
    @(posedge clk); #1;
    cfg_op = '0; wr_en = 1'b0;
    chk_flags("R6 rearm empties");
    rd(2, "R6 rearmed read underflows");
    wr(2, 32'h6001, "R6 after rearm");
    rd(2, "R6 after rearm");

    // R11 / R5: move ring 0 entry and reuse it
    cfg(1, 0, 33);
    cfg(3, 0, 5);
    for (int i = 0; i < 20; i++) wr(0, 32'h7000 + i, "R11 new entry");
    for (int i = 0; i < 20; i++) rd(0, "R11 new entry");

    repeat (3) @(negedge clk);
    if (eq.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d outstanding results, expected 0", eq.size());
    end
    report();
  end
endmodule